// File: doc/BRIEF.md
# OTP Word Repair Remapper

This block sits on the read path of a one-time-programmable memory array and hides defects found at manufacturing test. Cells that were never programmed read as 0 and programmed cells read as 1, so a fresh array and fresh repair tables are all zeros. Each read presents an address, the raw word the array returned for it, and that word's own repair field. The field names one bit and the value to force on it, which fixes a single leaky bit or a single bit that failed to program. A shared table of bit-repair entries covers words with more than one bad bit. A small word-retirement table sends any listed address to a spare word held inside the block.

The three levels are applied in a fixed order, and each later level overrides the one before it:

1. The per-word field is applied first.
2. Matching shared entries are applied next.
3. A match in the retirement table replaces the whole word.

Every table entry behaves like OTP. Once an entry has been written it is locked. Spare words can only gain 1 bits. The corrected word is registered and appears one cycle after the request, together with a valid flag.

Top module: `otp_repair_remap`

## Requirements
- R1: After reset, `rd_valid` and `rd_data` are 0, all table entries are empty and all spare words are zero, so a read returns the raw word changed only by its own repair field.
- R2: `rd_valid` is 1 in the cycle after a cycle with `rd_req`=1, and the corrected word is on `rd_data` in that same cycle. After a cycle with `rd_req`=0, `rd_valid` is 0 and `rd_data` keeps its previous value.
- R3: A read whose repair field has `fix_en`=0 and whose address matches no table entry returns `rd_raw` unchanged.
- R4: When `fix_en`=1, bit `fix_bit` of the result is forced to `fix_val`. This works in both directions: a 1 can become 0 (leaky bit) and a 0 can become 1 (failed programming). All other bits are untouched.
- R5: A shared bit-repair entry (`prog_kind`=1) whose stored address equals `rd_addr` forces its stored bit to its stored value. Every matching entry applies, and entries with other addresses have no effect.
- R6: A shared entry overrides the per-word field when both name the same bit. When several shared entries name the same bit, the entry in the lowest slot wins.
- R7: A retirement entry (`prog_kind`=0) whose stored address equals `rd_addr` makes the result equal to the spare word it names. The raw word and all bit repairs are ignored.
- R8: When several retirement entries match the same address, the entry in the lowest slot decides the spare word.
- R9: A write to a retirement or shared slot that already holds an entry is ignored, and the old entry keeps acting on reads.
- R10: A spare-word write (`prog_kind`=2, `prog_slot` selecting the spare) ORs `prog_data` into that spare word. Bits that are already 1 never return to 0.
- R11: A table write takes effect for reads issued in later cycles. A read issued in the same cycle as the write sees the tables as they were before it. `prog_kind`=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request for this cycle |
| rd_addr | input | ADDR_W | Read address |
| rd_raw | input | DATA_W | Raw word from the array at `rd_addr` |
| fix_en | input | 1 | Per-word repair field: enable |
| fix_bit | input | BIT_W | Per-word repair field: bit index |
| fix_val | input | 1 | Per-word repair field: forced value |
| prog_en | input | 1 | Table write strobe |
| prog_kind | input | 2 | 0 retirement entry, 1 shared bit entry, 2 spare word, 3 none |
| prog_slot | input | SLOT_W | Entry slot, or spare number for kind 2 |
| prog_addr | input | ADDR_W | Address stored in the entry |
| prog_bit | input | BIT_W | Bit index for a shared entry |
| prog_val | input | 1 | Forced value for a shared entry |
| prog_spare | input | SP_W | Spare word named by a retirement entry |
| prog_data | input | DATA_W | Bits to set in a spare word |
| rd_valid | output | 1 | Corrected word valid |
| rd_data | output | DATA_W | Corrected word |

## Verification
The assertions assume that `fix_bit` and the stored bit indices stay below DATA_W. They also assume that table slots and spare numbers are in range; a write with an out-of-range slot is simply dropped. The stimulus keeps every index within the word and every slot below its table depth. Programming happens only at clock-edge boundaries set from the falling edge, so the lock and only-set-bits properties always see a settled table. The one deliberate collision, a write and a read in the same cycle, is placed on a free slot, so the lock property still holds while the ordering rule is exercised.

// File: rtl/otp_rmp_pkg.sv
package otp_rmp_pkg;
  typedef enum logic [1:0] {
    PK_RETIRE = 2'd0,
    PK_BITFIX = 2'd1,
    PK_SPARE  = 2'd2,
    PK_NONE   = 2'd3
  } prog_kind_e;
endpackage

// File: rtl/otp_rmp_bitfix.sv
module otp_rmp_bitfix #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int N_ENT  = 4,
  parameter int SLOT_W = 2,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BIT_W-1:0]  wr_bit,
  input  logic              wr_val,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [DATA_W-1:0] word_in,
  output logic [DATA_W-1:0] word_out
);
  logic              vld_q  [N_ENT];
  logic [ADDR_W-1:0] addr_q [N_ENT];
  logic [BIT_W-1:0]  bit_q  [N_ENT];
  logic              val_q  [N_ENT];
  logic              vld_d  [N_ENT];
  logic [ADDR_W-1:0] addr_d [N_ENT];
  logic [BIT_W-1:0]  bit_d  [N_ENT];
  logic              val_d  [N_ENT];

  always_comb begin
    for (int i = 0; i < N_ENT; i++) begin
      vld_d[i]  = vld_q[i];
      addr_d[i] = addr_q[i];
      bit_d[i]  = bit_q[i];
      val_d[i]  = val_q[i];
      if (wr_en && (int'(wr_slot) == i) && !vld_q[i]) begin
        vld_d[i]  = 1'b1;
        addr_d[i] = wr_addr;
        bit_d[i]  = wr_bit;
        val_d[i]  = wr_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_ENT; i++) begin
        vld_q[i]  <= 1'b0;
        addr_q[i] <= '0;
        bit_q[i]  <= '0;
        val_q[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        vld_q[i]  <= vld_d[i];
        addr_q[i] <= addr_d[i];
        bit_q[i]  <= bit_d[i];
        val_q[i]  <= val_d[i];
      end
    end
  end

  // Highest slot is applied first so the lowest matching slot has the last word.
  always_comb begin
    word_out = word_in;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (vld_q[i] && (addr_q[i] == lk_addr)) begin
        word_out[bit_q[i]] = val_q[i];
      end
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_lock
    p_bitfix_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[g] |=> (vld_q[g] && addr_q[g] == $past(addr_q[g]) &&
                    bit_q[g] == $past(bit_q[g]) && val_q[g] == $past(val_q[g])));
  end
endmodule

// File: rtl/otp_rmp_retire.sv
module otp_rmp_retire #(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_WR    = 4,
  parameter int N_SPARE = 4,
  parameter int SLOT_W  = 2,
  localparam int SP_W   = (N_SPARE > 1) ? $clog2(N_SPARE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              map_wr,
  input  logic [SLOT_W-1:0] map_slot,
  input  logic [ADDR_W-1:0] map_addr,
  input  logic [SP_W-1:0]   map_spare,
  input  logic              sp_wr,
  input  logic [SLOT_W-1:0] sp_sel,
  input  logic [DATA_W-1:0] sp_bits,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              hit,
  output logic [DATA_W-1:0] spare_word
);
  logic              vld_q   [N_WR];
  logic [ADDR_W-1:0] addr_q  [N_WR];
  logic [SP_W-1:0]   idx_q   [N_WR];
  logic              vld_d   [N_WR];
  logic [ADDR_W-1:0] addr_d  [N_WR];
  logic [SP_W-1:0]   idx_d   [N_WR];
  logic [DATA_W-1:0] spare_q [N_SPARE];
  logic [DATA_W-1:0] spare_d [N_SPARE];
  logic [SP_W-1:0]   pick;

  always_comb begin
    for (int i = 0; i < N_WR; i++) begin
      vld_d[i]  = vld_q[i];
      addr_d[i] = addr_q[i];
      idx_d[i]  = idx_q[i];
      if (map_wr && (int'(map_slot) == i) && !vld_q[i]) begin
        vld_d[i]  = 1'b1;
        addr_d[i] = map_addr;
        idx_d[i]  = map_spare;
      end
    end
    for (int s = 0; s < N_SPARE; s++) begin
      spare_d[s] = spare_q[s];
      if (sp_wr && (int'(sp_sel) == s)) begin
        spare_d[s] = spare_q[s] | sp_bits;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_WR; i++) begin
        vld_q[i]  <= 1'b0;
        addr_q[i] <= '0;
        idx_q[i]  <= '0;
      end
      for (int s = 0; s < N_SPARE; s++) begin
        spare_q[s] <= '0;
      end
    end else begin
      for (int i = 0; i < N_WR; i++) begin
        vld_q[i]  <= vld_d[i];
        addr_q[i] <= addr_d[i];
        idx_q[i]  <= idx_d[i];
      end
      for (int s = 0; s < N_SPARE; s++) begin
        spare_q[s] <= spare_d[s];
      end
    end
  end

  // Address compare against every entry; lowest matching slot chooses the spare.
  always_comb begin
    hit  = 1'b0;
    pick = '0;
    for (int i = N_WR - 1; i >= 0; i--) begin
      if (vld_q[i] && (addr_q[i] == lk_addr)) begin
        hit  = 1'b1;
        pick = idx_q[i];
      end
    end
  end

  always_comb begin
    spare_word = '0;
    for (int s = 0; s < N_SPARE; s++) begin
      if (int'(pick) == s) spare_word = spare_q[s];
    end
  end

  for (genvar g = 0; g < N_WR; g++) begin : g_lock
    p_retire_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[g] |=> (vld_q[g] && addr_q[g] == $past(addr_q[g]) &&
                    idx_q[g] == $past(idx_q[g])));
  end

  for (genvar g = 0; g < N_SPARE; g++) begin : g_spare
    p_spare_only_sets_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (spare_q[g] & $past(spare_q[g])) == $past(spare_q[g]));
  end
endmodule

// File: rtl/otp_repair_remap.sv
module otp_repair_remap
  import otp_rmp_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter int N_WR    = 4,
  parameter int N_MB    = 4,
  parameter int N_SPARE = 4,
  localparam int BIT_W  = $clog2(DATA_W),
  localparam int SP_W   = (N_SPARE > 1) ? $clog2(N_SPARE) : 1,
  localparam int MAX_N  = (N_WR > N_MB) ? ((N_WR > N_SPARE) ? N_WR : N_SPARE)
                                        : ((N_MB > N_SPARE) ? N_MB : N_SPARE),
  localparam int SLOT_W = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_raw,
  input  logic              fix_en,
  input  logic [BIT_W-1:0]  fix_bit,
  input  logic              fix_val,
  input  logic              prog_en,
  input  logic [1:0]        prog_kind,
  input  logic [SLOT_W-1:0] prog_slot,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [BIT_W-1:0]  prog_bit,
  input  logic              prog_val,
  input  logic [SP_W-1:0]   prog_spare,
  input  logic [DATA_W-1:0] prog_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  prog_kind_e        kind;
  logic              wr_retire, wr_bitfix, wr_spare;
  logic [DATA_W-1:0] word_own, word_mb, spare_word, word_fin;
  logic              hit;
  logic              valid_d;
  logic [DATA_W-1:0] data_d;

  assign kind      = prog_kind_e'(prog_kind);
  assign wr_retire = prog_en && (kind == PK_RETIRE);
  assign wr_bitfix = prog_en && (kind == PK_BITFIX);
  assign wr_spare  = prog_en && (kind == PK_SPARE);

  // Level 1: the word's own repair field.
  always_comb begin
    word_own = rd_raw;
    if (fix_en) word_own[fix_bit] = fix_val;
  end

  // Level 2: shared bit-repair entries.
  otp_rmp_bitfix #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_ENT(N_MB), .SLOT_W(SLOT_W)
  ) u_bitfix (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_bitfix), .wr_slot(prog_slot), .wr_addr(prog_addr),
    .wr_bit(prog_bit), .wr_val(prog_val),
    .lk_addr(rd_addr), .word_in(word_own), .word_out(word_mb)
  );

  // Level 3: whole-word retirement.
  otp_rmp_retire #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_WR(N_WR), .N_SPARE(N_SPARE), .SLOT_W(SLOT_W)
  ) u_retire (
    .clk(clk), .rst_n(rst_n),
    .map_wr(wr_retire), .map_slot(prog_slot), .map_addr(prog_addr), .map_spare(prog_spare),
    .sp_wr(wr_spare), .sp_sel(prog_slot), .sp_bits(prog_data),
    .lk_addr(rd_addr), .hit(hit), .spare_word(spare_word)
  );

  assign word_fin = hit ? spare_word : word_mb;

  always_comb begin
    valid_d = rd_req;
    data_d  = rd_data;
    if (rd_req) data_d = word_fin;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= valid_d;
      rd_data  <= data_d;
    end
  end

  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> (!rd_valid && $stable(rd_data)));
  p_retired_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && hit) |=> (rd_data == $past(spare_word)));
  p_no_repair_passthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !hit && !fix_en && word_mb == rd_raw) |=> (rd_data == $past(rd_raw)));
endmodule

// File: tb/otp_repair_remap_bench.sv
module otp_repair_remap_bench;
  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NV = 11;
  localparam int VW = AW + DW + 1 + 5 + 1 + DW;

  logic          clk;
  logic          rst_n;
  logic          rd_req;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_raw;
  logic          fix_en;
  logic [4:0]    fix_bit;
  logic          fix_val;
  logic          prog_en;
  logic [1:0]    prog_kind;
  logic [1:0]    prog_slot;
  logic [AW-1:0] prog_addr;
  logic [4:0]    prog_bit;
  logic          prog_val;
  logic [1:0]    prog_spare;
  logic [DW-1:0] prog_data;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  int n_cmp;
  int n_bad;

  otp_repair_remap u_otp_repair_remap (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_raw(rd_raw),
    .fix_en(fix_en), .fix_bit(fix_bit), .fix_val(fix_val),
    .prog_en(prog_en), .prog_kind(prog_kind), .prog_slot(prog_slot),
    .prog_addr(prog_addr), .prog_bit(prog_bit), .prog_val(prog_val),
    .prog_spare(prog_spare), .prog_data(prog_data),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {addr, raw, fix_en, fix_bit, fix_val, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'h01, 32'hA5A5A5A5, 1'b0, 5'd0,  1'b0, 32'hA5A5A5A5},  // R3
    {8'h02, 32'h00000000, 1'b1, 5'd5,  1'b1, 32'h00000020},  // R4 failed program
    {8'h03, 32'hFFFFFFFF, 1'b1, 5'd31, 1'b0, 32'h7FFFFFFF},  // R4 leaky
    {8'h20, 32'h00000000, 1'b0, 5'd0,  1'b0, 32'h00000001},  // R5
    {8'h10, 32'h00000080, 1'b0, 5'd0,  1'b0, 32'h00000008},  // R5 R6 two entries
    {8'h10, 32'h00000000, 1'b1, 5'd3,  1'b0, 32'h00000008},  // R6 shared beats own
    {8'h10, 32'h00000000, 1'b1, 5'd4,  1'b1, 32'h00000018},  // R4 R5 combined
    {8'h30, 32'hDEADBEEF, 1'b1, 5'd0,  1'b1, 32'h0F00F0F0},  // R7 R8 R10
    {8'h40, 32'hFFFFFFFF, 1'b0, 5'd0,  1'b0, 32'h12345678},  // R7
    {8'h50, 32'hCAFEF00D, 1'b0, 5'd0,  1'b0, 32'hCAFEF00D},  // R3 free address
    {8'h11, 32'h00000008, 1'b0, 5'd0,  1'b0, 32'h00000008}   // R5 other address
  };

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [1:0] k, input logic [1:0] s, input logic [AW-1:0] a,
                      input logic [4:0] b, input logic v, input logic [1:0] sp,
                      input logic [DW-1:0] d);
    @(negedge clk);
    prog_en = 1'b1; prog_kind = k; prog_slot = s; prog_addr = a;
    prog_bit = b; prog_val = v; prog_spare = sp; prog_data = d;
    @(negedge clk);
    prog_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [DW-1:0] raw,
                    input logic fe, input logic [4:0] fb, input logic fv,
                    input logic [DW-1:0] exp);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a; rd_raw = raw; fix_en = fe; fix_bit = fb; fix_val = fv;
    @(negedge clk);
    rd_req = 1'b0; fix_en = 1'b0;
    chk({req, " valid"}, {31'd0, rd_valid}, 32'd1);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    n_cmp = 0; n_bad = 0;
    rst_n = 1'b0; rd_req = 1'b0; rd_addr = '0; rd_raw = '0;
    fix_en = 1'b0; fix_bit = '0; fix_val = 1'b0;
    prog_en = 1'b0; prog_kind = 2'd3; prog_slot = '0; prog_addr = '0;
    prog_bit = '0; prog_val = 1'b0; prog_spare = '0; prog_data = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {31'd0, rd_valid}, 32'd0);
    chk("R1 reset data", rd_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Kind 3 writes nothing (R11)
    prog(2'd3, 2'd0, 8'h01, 5'd0, 1'b1, 2'd0, 32'hFFFFFFFF);

    prog(2'd1, 2'd0, 8'h10, 5'd3, 1'b1, 2'd0, 32'h0);
    prog(2'd1, 2'd1, 8'h10, 5'd3, 1'b0, 2'd0, 32'h0);
    prog(2'd1, 2'd2, 8'h10, 5'd7, 1'b0, 2'd0, 32'h0);
    prog(2'd1, 2'd3, 8'h20, 5'd0, 1'b1, 2'd0, 32'h0);
    prog(2'd2, 2'd1, 8'h00, 5'd0, 1'b0, 2'd0, 32'h0000F0F0);
    prog(2'd2, 2'd1, 8'h00, 5'd0, 1'b0, 2'd0, 32'h0F000000);
    prog(2'd2, 2'd2, 8'h00, 5'd0, 1'b0, 2'd0, 32'h12345678);
    prog(2'd0, 2'd0, 8'h30, 5'd0, 1'b0, 2'd1, 32'h0);
    prog(2'd0, 2'd1, 8'h30, 5'd0, 1'b0, 2'd2, 32'h0);
    prog(2'd0, 2'd2, 8'h40, 5'd0, 1'b0, 2'd2, 32'h0);

    for (int i = 0; i < NV; i++) begin
      rd($sformatf("R3-R8 vec%0d", i), VEC[i][VW-1 -: AW], VEC[i][DW+7 +: DW],
         VEC[i][DW+6], VEC[i][DW+5 -: 5], VEC[i][DW], VEC[i][DW-1:0]);
    end

    // R11: write and read in the same cycle
    @(negedge clk);
    prog_en = 1'b1; prog_kind = 2'd0; prog_slot = 2'd3; prog_addr = 8'h50;
    prog_spare = 2'd0;
    rd_req = 1'b1; rd_addr = 8'h50; rd_raw = 32'h55AA55AA;
    @(negedge clk);
    prog_en = 1'b0; rd_req = 1'b0;
    chk("R11 same-cycle read", rd_data, 32'h55AA55AA);
    rd("R11 R7 later read empty spare", 8'h50, 32'h55AA55AA, 1'b0, 5'd0, 1'b0, 32'h0);

    // R9: locked slots ignore rewrites
    prog(2'd0, 2'd2, 8'h60, 5'd0, 1'b0, 2'd1, 32'h0);
    prog(2'd1, 2'd3, 8'h21, 5'd9, 1'b1, 2'd0, 32'h0);
    rd("R9 retire kept", 8'h40, 32'h0, 1'b0, 5'd0, 1'b0, 32'h12345678);
    rd("R9 retire not moved", 8'h60, 32'h00C0FFEE, 1'b0, 5'd0, 1'b0, 32'h00C0FFEE);
    rd("R9 bitfix kept", 8'h20, 32'h0, 1'b0, 5'd0, 1'b0, 32'h00000001);
    rd("R9 bitfix not moved", 8'h21, 32'h0, 1'b0, 5'd0, 1'b0, 32'h0);

    // R10: spare bits cannot be cleared by writing zeros
    prog(2'd2, 2'd2, 8'h00, 5'd0, 1'b0, 2'd0, 32'h00000000);
    rd("R10 spare unchanged", 8'h40, 32'h0, 1'b0, 5'd0, 1'b0, 32'h12345678);

    // R2: idle cycles hold data and drop valid
    rd("R2 read", 8'h01, 32'h13579BDF, 1'b0, 5'd0, 1'b0, 32'h13579BDF);
    rd_raw = 32'hFFFF0000; rd_addr = 8'h30;
    @(negedge clk);
    chk("R2 idle valid", {31'd0, rd_valid}, 32'd0);
    chk("R2 idle hold", rd_data, 32'h13579BDF);

    // R1: reset empties the tables
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset data again", rd_data, 32'd0);
    rst_n = 1'b1;
    rd("R1 retire cleared", 8'h30, 32'h00000011, 1'b0, 5'd0, 1'b0, 32'h00000011);
    rd("R1 bitfix cleared", 8'h10, 32'h0, 1'b1, 5'd2, 1'b1, 32'h00000004);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule